// File: doc/BRIEF.md
# Aliased Cycle Counter Register with Offset and Flag

This block presents one 64-bit time-stamp register that software can reach under two register names. Both names lead to the same state. Inside, a free-running 63-bit counter advances on every cycle in which the count-enable input is high. A stored 63-bit offset is added to that counter to form the visible count. Bit 63 of the register is not part of the count. It is a separate stored flag that reset sets to 1.

A write does not load the counter. It stores the difference between the written low 63 bits and the current free-running count. From that point the visible count continues from the written value. Reads are registered. A read strobe captures the flag together with bits 62 down to 2 of the visible count, and the two lowest bits always read as zero. The captured word stays on the read-data output until the next read strobe.

Top module: `tick_alias_reg`

## Requirements
- R1: After reset the flag is 1, and both the offset and the free-running count are 0. The read data holds 0 until the first read, and a first read with no counting returns 0x8000_0000_0000_0000.
- R2: The free-running count rises by exactly one on every cycle with `cnt_en` high and holds on every cycle with it low. A read strobe captures the count as it stood before that cycle's increment.
- R3: The visible count (free-running count plus offset, taken over 63 bits) wraps modulo 2^63. The wrap never changes the flag in bit 63.
- R4: A write (`acc_en`=1, `acc_wr`=1) makes the visible count equal to `wr_data[62:0]` at the write edge. A read issued in the following cycle returns that value with bits [1:0] cleared.
- R5: Bit 63 of a write is stored as the flag, independently of the count. Every later read returns it in bit 63.
- R6: Read data bits [1:0] are always 0, and bits [62:2] are the matching bits of the visible count.
- R7: Select code 0 (`acc_sel`=0) and select code 1 (`acc_sel`=1) reach the same state. A write through either code is seen by a read through either code.
- R8: The read data is a register loaded only on a read strobe (`acc_en`=1, `acc_wr`=0). It is valid one cycle after the strobe and is unchanged by counting, by writes and by idle cycles until the next read strobe.
- R9: When a write and a count increment fall in the same cycle, a read in the next cycle returns the written value plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Advances the free-running count by one this cycle |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_sel | input | 1 | Register name select; 0 and 1 alias the same state |
| wr_data | input | 64 | Write word: bit 63 is the flag, bits 62:0 the new count |
| rd_data | output | 64 | Registered read word: flag, count bits 62:2, two zero bits |

## Verification
Every result of this block lands at the first clock edge after its stimulus. A read strobe places its word on `rd_data` at that edge. A write changes the offset and flag at that edge, so it can first be observed by a read in the next cycle, whose data appears one edge later again. The bench drives inputs on falling edges and samples `rd_data` on the falling edge after each rising edge. On every cycle it compares `rd_data` against a behavioural model that is updated on the same rising edge. The directed checks wait one falling edge after each read strobe before they compare against a hand-derived constant.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int CNT_W  = 63;
  localparam int WORD_W = CNT_W + 1;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    SEL_TICK  = 1'b0,
    SEL_STICK = 1'b1
  } alias_sel_e;

  // Offset that makes (free + offset) equal target at this instant.
  function automatic cnt_t offset_for(cnt_t target, cnt_t free_now);
    return target - free_now;
  endfunction

  // Visible count, modulo 2^CNT_W.
  function automatic cnt_t visible(cnt_t free_now, cnt_t off);
    return free_now + off;
  endfunction

  // Assemble the architectural word: flag on top, low bits cleared.
  function automatic word_t pack_view(logic flag, cnt_t vis, int unsigned low_zero);
    word_t w;
    w = {flag, vis};
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(low_zero)) w[i] = 1'b0;
    end
    return w;
  endfunction

endpackage

// File: rtl/tick_access_dec.sv
module tick_access_dec
  import tick_pkg::*;
(
  input  logic acc_en,
  input  logic acc_wr,
  input  logic acc_sel,
  output logic wr_fire,
  output logic rd_fire
);

  logic hit_tick;
  logic hit_stick;
  logic hit_any;

  // Both register names decode onto the single shared state.
  assign hit_tick  = (alias_sel_e'(acc_sel) == SEL_TICK);
  assign hit_stick = (alias_sel_e'(acc_sel) == SEL_STICK);
  assign hit_any   = acc_en & (hit_tick | hit_stick);

  assign wr_fire = hit_any &  acc_wr;
  assign rd_fire = hit_any & ~acc_wr;

endmodule

// File: rtl/tick_free_ctr.sv
module tick_free_ctr
  import tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output cnt_t cnt_o
);

  cnt_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_offset_reg.sv
module tick_offset_reg
  import tick_pkg::*;
#(
  parameter logic RESET_FLAG = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  word_t wr_word_i,
  input  cnt_t  free_i,
  output cnt_t  off_o,
  output logic  flag_o
);

  cnt_t off_q;
  logic flag_q;
  cnt_t off_new;

  // Offset is taken against the count before this cycle's increment.
  // The counter and offset then advance together: the next visible
  // value is the written value plus any increment in the write cycle.
  assign off_new = offset_for(wr_word_i[CNT_W-1:0], free_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      flag_q <= RESET_FLAG;
    end else if (wr_i) begin
      off_q  <= off_new;
      flag_q <= wr_word_i[WORD_W-1];
    end
  end

  assign off_o  = off_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/tick_read_port.sv
module tick_read_port
  import tick_pkg::*;
#(
  parameter int unsigned LOW_ZERO = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_i,
  input  cnt_t  vis_i,
  input  logic  flag_i,
  output word_t rd_o
);

  localparam int unsigned KEEP_LO = (LOW_ZERO > CNT_W) ? CNT_W : LOW_ZERO;

  word_t view_w;
  word_t rd_q;

  assign view_w[WORD_W-1] = pack_view(flag_i, vis_i, KEEP_LO) >> (WORD_W-1);

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    if (b < int'(KEEP_LO)) begin : g_zero
      assign view_w[b] = 1'b0;
    end else begin : g_pass
      assign view_w[b] = vis_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_i) begin
      rd_q <= view_w;
    end
  end

  assign rd_o = rd_q;

endmodule

// File: rtl/tick_alias_reg.sv
module tick_alias_reg
  import tick_pkg::*;
#(
  parameter int unsigned LOW_ZERO   = 2,
  parameter logic        RESET_FLAG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_en,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic        acc_sel,
  input  logic [63:0] wr_data,
  output logic [63:0] rd_data
);

  logic  wr_fire;
  logic  rd_fire;
  cnt_t  free_cnt;
  cnt_t  offset;
  logic  flag;
  cnt_t  vis_cnt;
  word_t rd_word;

  tick_access_dec u_dec (
    .acc_en  (acc_en),
    .acc_wr  (acc_wr),
    .acc_sel (acc_sel),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  tick_free_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (cnt_en),
    .cnt_o  (free_cnt)
  );

  tick_offset_reg #(.RESET_FLAG(RESET_FLAG)) u_off (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_fire),
    .wr_word_i (wr_data),
    .free_i    (free_cnt),
    .off_o     (offset),
    .flag_o    (flag)
  );

  assign vis_cnt = visible(free_cnt, offset);

  tick_read_port #(.LOW_ZERO(LOW_ZERO)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (rd_fire),
    .vis_i  (vis_cnt),
    .flag_i (flag),
    .rd_o   (rd_word)
  );

  assign rd_data = rd_word;

endmodule

// File: rtl/tick_alias_chk.sv
module tick_alias_chk
  import tick_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_en,
  input logic        wr_fire,
  input logic        rd_fire,
  input logic [63:0] wr_data,
  input cnt_t        free_cnt,
  input cnt_t        offset,
  input logic        flag,
  input logic [63:0] rd_data
);

  cnt_t vis_now;
  assign vis_now = free_cnt + offset;

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> free_cnt == $past(free_cnt) + cnt_t'(1)); // R2
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(free_cnt)); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00); // R6
  AST_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> flag == $past(wr_data[63])); // R5
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> vis_now == $past(wr_data[62:0]) + cnt_t'($past(cnt_en))); // R9
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(offset) && $stable(flag)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data)); // R8
  AST_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_data[63] == $past(flag)); // R5

endmodule

bind tick_alias_reg tick_alias_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .wr_fire  (wr_fire),
  .rd_fire  (rd_fire),
  .wr_data  (wr_data),
  .free_cnt (free_cnt),
  .offset   (offset),
  .flag     (flag),
  .rd_data  (rd_data)
);

// File: tb/tb_tick_alias_reg.sv
`timescale 1ns/1ps
module tb_tick_alias_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_alias_reg dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .acc_en(acc_en),
    .acc_wr(acc_wr), .acc_sel(acc_sel), .wr_data(wr_data), .rd_data(rd_data)
  );

  // Behavioural reference model.
  logic [62:0] m_free = '0;
  logic [62:0] m_off = '0;
  logic        m_flag = 1'b1;
  logic [63:0] m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_free <= '0; m_off <= '0; m_flag <= 1'b1; m_rd <= '0;
    end else begin
      if (acc_en && !acc_wr) begin
        logic [62:0] v;
        v = m_free + m_off;
        m_rd <= {m_flag, v[62:2], 2'b00};
      end
      if (acc_en && acc_wr) begin
        m_off  <= wr_data[62:0] - m_free;
        m_flag <= wr_data[63];
      end
      if (cnt_en) m_free <= m_free + 63'd1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R8 latency and hold).
  always @(negedge clk) begin
    if (rst_n && !done) chk("R8 per-cycle", rd_data, m_rd);
  end

  task automatic cyc(logic en, logic a, logic w, logic s, logic [63:0] d);
    cnt_en = en; acc_en = a; acc_wr = w; acc_sel = s; wr_data = d;
    @(negedge clk);
    cnt_en = 1'b0; acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic idle(int n, logic en);
    for (int i = 0; i < n; i++) cyc(en, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic rd(logic s, logic en, output logic [63:0] v);
    cyc(en, 1'b1, 1'b0, s, '0);
    v = rd_data;
  endtask

  initial begin
    logic [63:0] v;
    @(negedge clk); @(negedge clk);
    chk("R1 reset rd_data", rd_data, 64'h0);
    rst_n = 1'b1;
    rd(1'b0, 1'b0, v);
    chk("R1 first read", v, 64'h8000_0000_0000_0000);

    idle(10, 1'b1);
    rd(1'b0, 1'b0, v);
    chk("R2 R6 after 10 counts", v, 64'h8000_0000_0000_0008);
    idle(5, 1'b0);
    rd(1'b1, 1'b1, v);
    chk("R2 hold, read before increment", v, 64'h8000_0000_0000_0008);
    idle(1, 1'b1);
    rd(1'b0, 1'b0, v);
    chk("R2 count 12", v, 64'h8000_0000_0000_000C);

    cyc(1'b0, 1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
    rd(1'b0, 1'b0, v);
    chk("R4 R5 R6 write then read", v, 64'h0123_4567_89AB_CDEC);
    rd(1'b1, 1'b0, v);
    chk("R7 read via alias", v, 64'h0123_4567_89AB_CDEC);

    cyc(1'b1, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0103);
    rd(1'b0, 1'b0, v);
    chk("R9 R7 R5 write with increment", v, 64'h8000_0000_0000_0104);

    idle(7, 1'b1);
    chk("R8 held while counting", rd_data, 64'h8000_0000_0000_0104);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_FFFF);
    chk("R8 held across write", rd_data, 64'h8000_0000_0000_0104);

    cyc(1'b0, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFE);
    rd(1'b1, 1'b0, v);
    chk("R4 near top", v, 64'h7FFF_FFFF_FFFF_FFFC);
    idle(3, 1'b1);
    rd(1'b0, 1'b0, v);
    chk("R3 wrap to 1", v, 64'h0);
    idle(4, 1'b1);
    rd(1'b0, 1'b0, v);
    chk("R3 after wrap", v, 64'h4);

    cyc(1'b0, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(1, 1'b1);
    rd(1'b1, 1'b0, v);
    chk("R3 R5 wrap keeps flag", v, 64'h8000_0000_0000_0000);

    idle(2, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule